// File: doc/BRIEF.md
# Code Segment Pointer Address Extender

This block holds the number of the code segment that instructions are currently fetched from. It builds the full code fetch address by placing that segment number directly above the 16-bit instruction pointer, which gives a 24-bit address. The instruction sequencer drives the block with one-cycle strobes. Far jumps and far calls load a segment taken from the instruction. Far returns and interrupt returns load a segment popped from the stack. Accepting an interrupt, or executing a software trap, sends execution back to segment zero. Ordinary data writes cannot change the segment register, but data reads return its value.

A segmentation enable selects between segmented and flat operation. In flat operation the stored segment is kept but ignored, and every fetch address lies in segment 0. A 2-bit width select and an external-access flag control how many low segment bits appear on the external segment address pins. All other pin bits are driven low.

Top module: `cseg_addr_ext`

## Requirements
- R1: With `seg_en` high, `code_addr` equals the stored 8-bit segment in bits 23..16 and `ip_in` in bits 15..0.
- R2: `rd_val` returns the stored segment in bits 7..0, with bits 15..8 always zero.
- R3: After a synchronous reset (`rst` high at a clock edge) the stored segment is 0, so `rd_val` is 0x0000.
- R4: A data write (`data_wr_en` with any `data_wr_data`) leaves the stored segment unchanged. With no strobe active, the segment holds its value.
- R5: A cycle with `far_jmp` or `far_call` high loads `seg_val` into the stored segment.
- R6: A cycle with `far_ret` or `int_ret` high loads `seg_val`, which carries the segment restored from the stack.
- R7: A cycle with `int_ack` or `trap` high clears the stored segment to 0. This holds even when a load strobe is active in the same cycle.
- R8: With `seg_en` low, `code_addr[23:16]` is 0 and `code_addr[15:0]` equals `ip_in`. The stored segment is unaffected and still readable.
- R9: `seg_pins` carries the low N stored segment bits, with all higher bits 0, only when `seg_en` and `ext_acc` are both high. The `pin_sel` code gives N: 00 → 0, 01 → 2, 10 → 4, 11 → 8. Otherwise `seg_pins` is 0.
- R10: A new segment takes effect at the clock edge that samples its strobe. Before that edge, `code_addr` still shows the old segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ip_in | input | 16 | Current instruction pointer |
| far_jmp | input | 1 | Far jump strobe |
| far_call | input | 1 | Far call strobe |
| far_ret | input | 1 | Far return strobe |
| int_ret | input | 1 | Interrupt return strobe |
| int_ack | input | 1 | Interrupt acceptance strobe |
| trap | input | 1 | Software trap strobe |
| seg_val | input | 8 | New segment operand or popped segment |
| seg_en | input | 1 | Segmentation enable |
| pin_sel | input | 2 | Number of segment bits driven to pins |
| ext_acc | input | 1 | Current code access is external |
| data_wr_en | input | 1 | Data-operation write strobe (ignored) |
| data_wr_data | input | 16 | Data-operation write value (ignored) |
| code_addr | output | 24 | Full code fetch address |
| seg_pins | output | 8 | Masked segment bits for external pins |
| rd_val | output | 16 | Register value for data reads |

## Verification
The stored segment changes only at a clock edge. Every value loaded or cleared by a strobe is therefore due on `rd_val`, `code_addr` and `seg_pins` one edge after the cycle in which the bench drives the strobe. `code_addr` and `seg_pins` also follow `ip_in`, `seg_en`, `pin_sel` and `ext_acc` combinationally within the same cycle. The bench drives inputs on the falling edge and samples one time unit after the next rising edge. The R10 test also samples just before that rising edge, to confirm that the old segment is still visible there.

// File: rtl/cseg_pkg.sv
package cseg_pkg;

  typedef enum logic [1:0] {
    PINS_NONE = 2'b00,
    PINS_TWO  = 2'b01,
    PINS_FOUR = 2'b10,
    PINS_ALL  = 2'b11
  } pin_sel_e;

  // Number of low segment bits routed to the pins for a select code.
  function automatic int unsigned pin_count(input pin_sel_e sel, input int unsigned seg_w);
    int unsigned n;
    case (sel)
      PINS_NONE: n = 0;
      PINS_TWO:  n = 2;
      PINS_FOUR: n = 4;
      default:   n = seg_w;
    endcase
    if (n > seg_w) n = seg_w;
    return n;
  endfunction

endpackage

// File: rtl/cseg_event_arb.sv
module cseg_event_arb #(
  parameter int SEG_W = 8
) (
  input  logic             far_jmp,
  input  logic             far_call,
  input  logic             far_ret,
  input  logic             int_ret,
  input  logic             int_ack,
  input  logic             trap,
  input  logic [SEG_W-1:0] seg_val,
  output logic             upd_en,
  output logic [SEG_W-1:0] upd_val
);
  logic clr_req;
  logic ld_req;

  always_comb begin
    clr_req = int_ack | trap;
    ld_req  = far_jmp | far_call | far_ret | int_ret;
    upd_en  = clr_req | ld_req;
    // Interrupt or trap outranks any branch or return load.
    upd_val = clr_req ? '0 : seg_val;
  end
endmodule

// File: rtl/cseg_reg.sv
module cseg_reg #(
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic [SEG_W-1:0] upd_val,
  output logic [SEG_W-1:0] seg_q
);
  always_ff @(posedge clk) begin
    if (rst)         seg_q <= '0;
    else if (upd_en) seg_q <= upd_val;
  end
endmodule

// File: rtl/cseg_pin_mask.sv
module cseg_pin_mask
  import cseg_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  logic [SEG_W-1:0] seg_q,
  input  logic [1:0]       pin_sel,
  input  logic             drive_en,
  output logic [SEG_W-1:0] seg_pins
);
  localparam int CNT_W = $clog2(SEG_W + 1);

  logic [CNT_W-1:0] cnt;
  logic [SEG_W-1:0] mask;

  always_comb cnt = CNT_W'(pin_count(pin_sel_e'(pin_sel), SEG_W));

  for (genvar i = 0; i < SEG_W; i++) begin : g_mask
    assign mask[i] = (CNT_W'(i) < cnt);
  end

  assign seg_pins = drive_en ? (seg_q & mask) : '0;
endmodule

// File: rtl/cseg_addr_ext.sv
module cseg_addr_ext #(
  parameter int SEG_W = 8,
  parameter int IP_W  = 16,
  parameter int RD_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [IP_W-1:0]       ip_in,
  input  logic                  far_jmp,
  input  logic                  far_call,
  input  logic                  far_ret,
  input  logic                  int_ret,
  input  logic                  int_ack,
  input  logic                  trap,
  input  logic [SEG_W-1:0]      seg_val,
  input  logic                  seg_en,
  input  logic [1:0]            pin_sel,
  input  logic                  ext_acc,
  input  logic                  data_wr_en,
  input  logic [RD_W-1:0]       data_wr_data,
  output logic [SEG_W+IP_W-1:0] code_addr,
  output logic [SEG_W-1:0]      seg_pins,
  output logic [RD_W-1:0]       rd_val
);
  localparam int PAD_W = RD_W - SEG_W;

  logic             upd_en;
  logic [SEG_W-1:0] upd_val;
  logic [SEG_W-1:0] seg_q;
  logic [SEG_W-1:0] seg_eff;

  cseg_event_arb #(.SEG_W(SEG_W)) u_arb (
    .far_jmp (far_jmp),
    .far_call(far_call),
    .far_ret (far_ret),
    .int_ret (int_ret),
    .int_ack (int_ack),
    .trap    (trap),
    .seg_val (seg_val),
    .upd_en  (upd_en),
    .upd_val (upd_val)
  );

  cseg_reg #(.SEG_W(SEG_W)) u_reg (
    .clk    (clk),
    .rst    (rst),
    .upd_en (upd_en),
    .upd_val(upd_val),
    .seg_q  (seg_q)
  );

  cseg_pin_mask #(.SEG_W(SEG_W)) u_pins (
    .seg_q   (seg_q),
    .pin_sel (pin_sel),
    .drive_en(seg_en & ext_acc),
    .seg_pins(seg_pins)
  );

  // Flat mode forces segment 0 without touching the stored value.
  assign seg_eff   = seg_en ? seg_q : '0;
  assign code_addr = {seg_eff, ip_in};
  assign rd_val    = {{PAD_W{1'b0}}, seg_q};
endmodule

// File: rtl/cseg_addr_ext_chk.sv
module cseg_addr_ext_chk #(
  parameter int SEG_W = 8,
  parameter int IP_W  = 16,
  parameter int RD_W  = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic [IP_W-1:0]       ip_in,
  input logic                  far_jmp,
  input logic                  far_call,
  input logic                  far_ret,
  input logic                  int_ret,
  input logic                  int_ack,
  input logic                  trap,
  input logic [SEG_W-1:0]      seg_val,
  input logic                  seg_en,
  input logic                  ext_acc,
  input logic                  data_wr_en,
  input logic [RD_W-1:0]       data_wr_data,
  input logic [SEG_W+IP_W-1:0] code_addr,
  input logic [SEG_W-1:0]      seg_pins,
  input logic [RD_W-1:0]       rd_val
);
  logic any_ld;
  logic any_clr;
  assign any_ld  = far_jmp | far_call | far_ret | int_ret;
  assign any_clr = int_ack | trap;

  a_r3_reset_zero: assert property (@(posedge clk) $past(rst) |-> rd_val == '0);

  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    any_clr |=> rd_val[SEG_W-1:0] == '0);

  a_r5_r6_load: assert property (@(posedge clk) disable iff (rst)
    (any_ld && !any_clr) |=> rd_val[SEG_W-1:0] == $past(seg_val));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!any_ld && !any_clr && (data_wr_en || data_wr_data != '0) || !(any_ld || any_clr))
      |=> $stable(rd_val));

  a_r8_flat: assert property (@(posedge clk) disable iff (rst)
    !seg_en |-> (code_addr[SEG_W+IP_W-1:IP_W] == '0 && code_addr[IP_W-1:0] == ip_in));

  a_r9_pins_off: assert property (@(posedge clk) disable iff (rst)
    !(seg_en && ext_acc) |-> seg_pins == '0);

  a_r1_addr: assert property (@(posedge clk) disable iff (rst)
    seg_en |-> code_addr[SEG_W+IP_W-1:IP_W] == rd_val[SEG_W-1:0]);
endmodule

bind cseg_addr_ext cseg_addr_ext_chk #(.SEG_W(SEG_W), .IP_W(IP_W), .RD_W(RD_W)) u_chk (
  .clk(clk), .rst(rst), .ip_in(ip_in), .far_jmp(far_jmp), .far_call(far_call),
  .far_ret(far_ret), .int_ret(int_ret), .int_ack(int_ack), .trap(trap),
  .seg_val(seg_val), .seg_en(seg_en), .ext_acc(ext_acc), .data_wr_en(data_wr_en),
  .data_wr_data(data_wr_data), .code_addr(code_addr), .seg_pins(seg_pins), .rd_val(rd_val)
);

// File: tb/cseg_addr_ext_tb.sv
module cseg_addr_ext_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] ip_in;
  logic        far_jmp, far_call, far_ret, int_ret, int_ack, trap;
  logic [7:0]  seg_val;
  logic        seg_en;
  logic [1:0]  pin_sel;
  logic        ext_acc;
  logic        data_wr_en;
  logic [15:0] data_wr_data;
  logic [23:0] code_addr;
  logic [7:0]  seg_pins;
  logic [15:0] rd_val;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  cseg_addr_ext u_dut (
    .clk(clk), .rst(rst), .ip_in(ip_in), .far_jmp(far_jmp), .far_call(far_call),
    .far_ret(far_ret), .int_ret(int_ret), .int_ack(int_ack), .trap(trap),
    .seg_val(seg_val), .seg_en(seg_en), .pin_sel(pin_sel), .ext_acc(ext_acc),
    .data_wr_en(data_wr_en), .data_wr_data(data_wr_data),
    .code_addr(code_addr), .seg_pins(seg_pins), .rd_val(rd_val)
  );

  // Row: ev{trap,int_ack,int_ret,far_ret,far_call,far_jmp}, val, ip, en, sel, ext, exp_seg, exp_pins
  localparam int NV = 10;
  localparam logic [49:0] VEC [NV] = '{
    {6'b000001, 8'hA5, 16'h1234, 1'b1, 2'b11, 1'b1, 8'hA5, 8'hA5},
    {6'b000000, 8'h3C, 16'h0010, 1'b1, 2'b10, 1'b1, 8'hA5, 8'h05},
    {6'b000010, 8'h7E, 16'hBEEF, 1'b1, 2'b01, 1'b1, 8'h7E, 8'h02},
    {6'b100000, 8'h11, 16'h0002, 1'b1, 2'b11, 1'b1, 8'h00, 8'h00},
    {6'b000100, 8'hC3, 16'h4000, 1'b1, 2'b00, 1'b1, 8'hC3, 8'h00},
    {6'b000000, 8'h00, 16'hFFFF, 1'b0, 2'b11, 1'b1, 8'hC3, 8'h00},
    {6'b001000, 8'h5A, 16'h0800, 1'b1, 2'b11, 1'b0, 8'h5A, 8'h00},
    {6'b010001, 8'hFF, 16'h0100, 1'b1, 2'b11, 1'b1, 8'h00, 8'h00},
    {6'b000001, 8'h96, 16'h7777, 1'b1, 2'b10, 1'b1, 8'h96, 8'h06},
    {6'b101000, 8'h44, 16'h0001, 1'b1, 2'b11, 1'b1, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    {trap, int_ack, int_ret, far_ret, far_call, far_jmp} = '0;
    data_wr_en = 1'b0;
    data_wr_data = '0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; idle(); ip_in = 16'h0; seg_val = 8'h0;
    seg_en = 1'b1; pin_sel = 2'b11; ext_acc = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R3 reset rd_val", {8'h0, rd_val}, 24'h0);
    chk("R3 reset pins", {16'h0, seg_pins}, 24'h0);

    // Vector table: R1 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      logic [23:0] ea;
      v = VEC[i];
      @(negedge clk);
      {trap, int_ack, int_ret, far_ret, far_call, far_jmp} = v[49:44];
      seg_val = v[43:36]; ip_in = v[35:20]; seg_en = v[19];
      pin_sel = v[18:17]; ext_acc = v[16];
      @(posedge clk); #1;
      ea = v[19] ? {v[15:8], v[35:20]} : {8'h00, v[35:20]};
      chk($sformatf("R5/R6/R7 row %0d rd_val", i), {8'h0, rd_val}, {16'h0, v[15:8]});
      chk($sformatf("R1/R8 row %0d code_addr", i), code_addr, ea);
      chk($sformatf("R9 row %0d seg_pins", i), {16'h0, seg_pins}, {16'h0, v[7:0]});
      @(negedge clk); idle();
    end

    // R4: data writes ignored; segment currently 0 -> load 3B first
    @(negedge clk); far_jmp = 1'b1; seg_val = 8'h3B; seg_en = 1'b1; ip_in = 16'h0042;
    @(negedge clk); idle(); data_wr_en = 1'b1; data_wr_data = 16'hF0F0; seg_val = 8'hEE;
    @(posedge clk); #1;
    @(negedge clk); data_wr_data = 16'h0001;
    @(posedge clk); #1;
    chk("R4 write ignored rd_val", {8'h0, rd_val}, 24'h00003B);
    chk("R2 upper read zero", {16'h0, rd_val[15:8]}, 24'h0);
    @(negedge clk); idle();

    // R8: flat mode keeps stored value readable
    seg_en = 1'b0; ip_in = 16'hABCD; #1;
    chk("R8 flat code_addr", code_addr, 24'h00ABCD);
    chk("R8 stored kept", {8'h0, rd_val}, 24'h00003B);
    seg_en = 1'b1; #1;
    chk("R1 segmented code_addr", code_addr, 24'h3BABCD);

    // R10: old segment visible before edge, new after
    @(negedge clk); far_call = 1'b1; seg_val = 8'h81; #1;
    chk("R10 before edge", code_addr, 24'h3BABCD);
    @(posedge clk); #1;
    chk("R10 after edge", code_addr, 24'h81ABCD);
    @(negedge clk); idle();

    // R9: pins zero for internal access, then width 2
    ext_acc = 1'b0; pin_sel = 2'b11; #1;
    chk("R9 internal pins zero", {16'h0, seg_pins}, 24'h0);
    ext_acc = 1'b1; pin_sel = 2'b01; #1;
    chk("R9 two-bit pins", {16'h0, seg_pins}, 24'h000001);

    // R3: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R3 mid-run reset", {8'h0, rd_val}, 24'h0);
    @(negedge clk); rst = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule